// File: doc/BRIEF.md
# Ethernet PHY status LED controller

This block drives a small set of status LEDs (three by default) for a multi-speed Ethernet PHY. It watches the link state (link up, one of four line speeds, duplex) and single-cycle activity strobes for transmit, receive and collision. From these it decides, LED by LED, whether the LED is dark, steadily lit or blinking.

Each LED has two registers. The first is a 16-bit rule register. Its bits choose which link conditions light the LED steadily, which conditions make it blink, and which activity strobes stretch into a short fixed-length flash. The second is a control register whose top three bits either take manual control of the LED (dark, lit, or a free-running blink at one of two rates) or leave it under rule control with one of four blink waveforms.

A shared polarity register sets whether lit means a high or a low output level. All timing is derived from a clock-to-millisecond divider, so the blink period and flash length are set in milliseconds.

Top module: `phy_led_ctrl`

## Requirements
- R1: After reset every register reads 0x0000, every LED is in rule mode with waveform code 0, and outputs are active low, so `led_out` is all ones.
- R2: Rule register of LED n is at 0x8078 − 2n and its control register is at 0x8079 − 2n, for n = 0 to N_LED−1. The polarity register is at 0x901A. Writes take effect at the clock edge and read back unchanged. `reg_rdata` shows the register addressed at the previous edge. Any other address, including the would-be LED index N_LED (0x8072/0x8073), reads 0 and a write to it changes nothing.
- R3: Control bits 15:13 = 4 forces the LED dark and 5 forces it lit, whatever the rules and link inputs are. The output register adds one cycle of latency.
- R4: Control code 6 blinks with a period of PERIOD_MS ms and half of it lit. Code 7 blinks at twice that rate with the same 50 % duty.
- R5: In rule mode (codes 0 to 3), with the speed encoded 0=10, 1=100, 2=1000, 3=2500, the LED is steadily lit when the link is up and at least one enabled condition matches. The conditions are: bit 15 and speed 2500, bit 6 and 1000, bit 5 and 100, bit 4 and 10, bit 12 and full duplex, bit 11 and half duplex. With the link down none of these light it.
- R6: In rule mode an activity strobe enabled by bit 10 (TX), bit 9 (RX) or bit 3 (collision) replaces the steady state with the selected waveform for exactly PERIOD_MS·CLK_PER_MS cycles after the last such strobe. Waveform codes are: 0 = double rate 50 %, 1 = 25 % lit, 2 = 75 % lit, 3 = base rate 50 %.
- R7: Activity blinking needs a matching steady condition of R5 unless bit 13 (bypass) is set. With bypass set it follows activity regardless of link, speed and duplex.
- R8: Bit 8 (TX) and bit 7 (RX) stretch each strobe into a lit interval of exactly STRETCH_MS·CLK_PER_MS cycles, independent of link state.
- R9: Polarity register bit 6 set makes outputs active high. No other bit of that register changes the output level.
- R10: Bits 14, 2, 1, 0 make the LED show the selected waveform continuously while the link is up at 2500, 1000, 100 and 10 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | 0=10, 1=100, 2=1000, 3=2500 |
| full_duplex | input | 1 | 1 = full duplex, 0 = half |
| tx_strobe | input | 1 | One-cycle transmit activity pulse |
| rx_strobe | input | 1 | One-cycle receive activity pulse |
| col_strobe | input | 1 | One-cycle collision pulse |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 16 | Register address (read and write) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| led_out | output | N_LED | LED drive levels after polarity |

## Verification
The case where two functions meet in one cycle is a control-register write that arrives in the same cycle as an activity strobe. The write moves a LED out of forced-lit into rule mode while a TX strobe arrives. The bench drives both on the same edge. It then counts lit cycles over two blink periods and expects exactly the duty of one hold window. This shows that the strobe was captured even though the LED was forced at that moment, and that the new code governed the output from the following cycle. A second overlap is steady-on plus activity. There the expected count is the hold-window duty plus one full period of steady light.

// File: rtl/led_pkg.sv
package led_pkg;
  // rule register bit positions
  localparam int B_ON_2500   = 15;
  localparam int B_BL_2500   = 14;
  localparam int B_BYPASS    = 13;
  localparam int B_ON_FD     = 12;
  localparam int B_ON_HD     = 11;
  localparam int B_BL_TX     = 10;
  localparam int B_BL_RX     = 9;
  localparam int B_ST_TX     = 8;
  localparam int B_ST_RX     = 7;
  localparam int B_ON_1000   = 6;
  localparam int B_ON_100    = 5;
  localparam int B_ON_10     = 4;
  localparam int B_BL_COL    = 3;
  localparam int B_BL_1000   = 2;
  localparam int B_BL_100    = 1;
  localparam int B_BL_10     = 0;

  // control field codes (bits 15:13)
  localparam logic [2:0] CTL_DARK  = 3'd4;
  localparam logic [2:0] CTL_LIT   = 3'd5;
  localparam logic [2:0] CTL_SLOW  = 3'd6;
  localparam logic [2:0] CTL_FAST  = 3'd7;

  localparam int POL_BIT = 6;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_2500 = 2'd3
  } speed_e;
endpackage

// File: rtl/led_timebase.sv
module led_timebase #(
  parameter int CLK_PER_MS = 125000,
  parameter int PERIOD_MS  = 250
) (
  input  logic       clk,
  input  logic       rst,
  output logic [3:0] wave_o   // [0] fast 50%, [1] 25%, [2] 75%, [3] slow 50%
);
  localparam int DIV_W = $clog2(CLK_PER_MS + 1);
  localparam int PH_W  = $clog2(PERIOD_MS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_MS - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PERIOD_MS - 1);
  localparam logic [PH_W-1:0]  HALF     = PH_W'(PERIOD_MS / 2);
  localparam logic [PH_W-1:0]  Q3       = PH_W'((PERIOD_MS * 3) / 4);
  localparam logic [PH_W-1:0]  Q1       = PH_W'(PERIOD_MS / 4);
  localparam logic [PH_W-1:0]  FAST_ON  = PH_W'((PERIOD_MS / 2 + 1) / 2);

  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  phase_q;
  logic [PH_W-1:0]  fast_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      phase_q <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q   <= '0;
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign fast_ph = (phase_q >= HALF) ? phase_q - HALF : phase_q;

  always_comb begin
    wave_o[0] = fast_ph < FAST_ON;
    wave_o[1] = phase_q < Q1;
    wave_o[2] = phase_q < Q3;
    wave_o[3] = phase_q < HALF;
  end

  p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
    phase_q <= PH_LAST);
  p_phase_step_r4: assert property (@(posedge clk) disable iff (rst)
    (div_q != DIV_LAST) |=> $stable(phase_q));
endmodule

// File: rtl/led_activity.sv
module led_activity #(
  parameter int HOLD_CYC    = 1000,
  parameter int STRETCH_CYC = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] strobe_i,   // [0] tx, [1] rx, [2] collision
  output logic [2:0] hold_o,
  output logic [1:0] stretch_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int SW = $clog2(STRETCH_CYC + 1);

  for (genvar i = 0; i < 3; i++) begin : g_hold
    logic [HW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (strobe_i[i]) cnt <= HW'(HOLD_CYC);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign hold_o[i] = (cnt != '0);

    p_hold_load_r6: assert property (@(posedge clk) disable iff (rst)
      strobe_i[i] |=> hold_o[i]);
  end

  for (genvar j = 0; j < 2; j++) begin : g_stretch
    logic [SW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (strobe_i[j]) cnt <= SW'(STRETCH_CYC);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign stretch_o[j] = (cnt != '0);

    p_stretch_decay_r8: assert property (@(posedge clk) disable iff (rst)
      (!strobe_i[j] && !stretch_o[j]) |=> !stretch_o[j]);
  end
endmodule

// File: rtl/led_regs.sv
module led_regs #(
  parameter int          N_LED    = 3,
  parameter logic [15:0] RULE_TOP = 16'h8078,
  parameter logic [15:0] POL_ADDR = 16'h901A
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [15:0]            addr,
  input  logic [15:0]            wdata,
  output logic [15:0]            rdata,
  output logic [N_LED-1:0][15:0] rule_o,
  output logic [N_LED-1:0][2:0]  code_o,
  output logic                   act_high_o
);
  localparam logic [15:0] FIRST_BAD = RULE_TOP - 16'(2 * N_LED);

  logic [N_LED-1:0][15:0] rule_q;
  logic [N_LED-1:0][15:0] ctl_q;
  logic [15:0]            pol_q;
  logic [15:0]            rd_mux;

  function automatic logic [15:0] rule_addr(input int n);
    return RULE_TOP - 16'(2 * n);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rule_q <= '0;
      ctl_q  <= '0;
      pol_q  <= '0;
    end else if (we) begin
      for (int n = 0; n < N_LED; n++) begin
        if (addr == rule_addr(n))         rule_q[n] <= wdata;
        if (addr == rule_addr(n) + 16'd1) ctl_q[n]  <= wdata;
      end
      if (addr == POL_ADDR) pol_q <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < N_LED; n++) begin
      if (addr == rule_addr(n))         rd_mux = rule_q[n];
      if (addr == rule_addr(n) + 16'd1) rd_mux = ctl_q[n];
    end
    if (addr == POL_ADDR) rd_mux = pol_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  for (genvar n = 0; n < N_LED; n++) begin : g_out
    assign rule_o[n] = rule_q[n];
    assign code_o[n] = ctl_q[n][15:13];
  end
  assign act_high_o = pol_q[led_pkg::POL_BIT];

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (addr == FIRST_BAD || addr == FIRST_BAD + 16'd1) |=> (rdata == 16'h0000));
endmodule

// File: rtl/led_lane.sv
module led_lane
  import led_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] rule_i,
  input  logic [2:0]  code_i,
  input  logic        act_high_i,
  input  logic        link_i,
  input  logic [1:0]  speed_i,
  input  logic        fd_i,
  input  logic [2:0]  hold_i,
  input  logic [1:0]  stretch_i,
  input  logic [3:0]  wave_i,
  output logic        led_o
);
  speed_e spd;
  logic   spd_on, dup_on, match, spd_blink, act, blink_req, steady, hw_lit, lit;

  assign spd = speed_e'(speed_i);

  always_comb begin
    spd_on = (rule_i[B_ON_2500] && spd == SPD_2500) ||
             (rule_i[B_ON_1000] && spd == SPD_1000) ||
             (rule_i[B_ON_100]  && spd == SPD_100)  ||
             (rule_i[B_ON_10]   && spd == SPD_10);
    dup_on = (rule_i[B_ON_FD] && fd_i) || (rule_i[B_ON_HD] && !fd_i);
    match  = link_i && (spd_on || dup_on);
    spd_blink = link_i && ((rule_i[B_BL_2500] && spd == SPD_2500) ||
                           (rule_i[B_BL_1000] && spd == SPD_1000) ||
                           (rule_i[B_BL_100]  && spd == SPD_100)  ||
                           (rule_i[B_BL_10]   && spd == SPD_10));
    act = (rule_i[B_BL_TX] && hold_i[0]) || (rule_i[B_BL_RX] && hold_i[1]) ||
          (rule_i[B_BL_COL] && hold_i[2]);
    blink_req = spd_blink || (act && (rule_i[B_BYPASS] || match));
    steady = match || (rule_i[B_ST_TX] && stretch_i[0]) ||
             (rule_i[B_ST_RX] && stretch_i[1]);
    hw_lit = blink_req ? wave_i[code_i[1:0]] : steady;
    unique case (code_i)
      CTL_DARK: lit = 1'b0;
      CTL_LIT:  lit = 1'b1;
      CTL_SLOW: lit = wave_i[3];
      CTL_FAST: lit = wave_i[0];
      default:  lit = hw_lit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) led_o <= 1'b1;
    else     led_o <= act_high_i ? lit : !lit;
  end

  p_forced_dark_r3: assert property (@(posedge clk) disable iff (rst)
    (code_i == CTL_DARK) |=> (led_o == !$past(act_high_i)));
  p_forced_lit_r3: assert property (@(posedge clk) disable iff (rst)
    (code_i == CTL_LIT) |=> (led_o == $past(act_high_i)));
  p_dark_link_down_r5: assert property (@(posedge clk) disable iff (rst)
    (!code_i[2] && !link_i && !rule_i[B_ST_TX] && !rule_i[B_ST_RX] && !rule_i[B_BYPASS])
      |=> (led_o == !$past(act_high_i)));
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl #(
  parameter int CLK_PER_MS = 125000,
  parameter int PERIOD_MS  = 250,
  parameter int STRETCH_MS = 10,
  parameter int N_LED      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic [1:0]       link_speed,
  input  logic             full_duplex,
  input  logic             tx_strobe,
  input  logic             rx_strobe,
  input  logic             col_strobe,
  input  logic             reg_we,
  input  logic [15:0]      reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic [N_LED-1:0] led_out
);
  localparam int HOLD_CYC    = PERIOD_MS * CLK_PER_MS;
  localparam int STRETCH_CYC = STRETCH_MS * CLK_PER_MS;

  logic [N_LED-1:0][15:0] rule;
  logic [N_LED-1:0][2:0]  code;
  logic                   act_high;
  logic [3:0]             wave;
  logic [2:0]             hold;
  logic [1:0]             stretch;

  led_regs #(.N_LED(N_LED)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .rule_o(rule), .code_o(code), .act_high_o(act_high)
  );

  led_timebase #(.CLK_PER_MS(CLK_PER_MS), .PERIOD_MS(PERIOD_MS)) u_tb (
    .clk(clk), .rst(rst), .wave_o(wave)
  );

  led_activity #(.HOLD_CYC(HOLD_CYC), .STRETCH_CYC(STRETCH_CYC)) u_act (
    .clk(clk), .rst(rst), .strobe_i({col_strobe, rx_strobe, tx_strobe}),
    .hold_o(hold), .stretch_o(stretch)
  );

  for (genvar n = 0; n < N_LED; n++) begin : g_lane
    led_lane u_lane (
      .clk(clk), .rst(rst), .rule_i(rule[n]), .code_i(code[n]),
      .act_high_i(act_high), .link_i(link_up), .speed_i(link_speed),
      .fd_i(full_duplex), .hold_i(hold), .stretch_i(stretch),
      .wave_i(wave), .led_o(led_out[n])
    );
  end

  p_reset_dark_r1: assert property (@(posedge clk)
    $past(rst) |-> (led_out == {N_LED{1'b1}}));
endmodule

// File: tb/tb_phy_led_ctrl.sv
module tb_phy_led_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CPM = 2;
  localparam int PMS = 8;
  localparam int SMS = 3;
  localparam int P   = PMS * CPM;   // 16 cycles per blink period
  localparam int S   = SMS * CPM;   // 6 cycles of stretch

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_up = 1'b0;
  logic [1:0]  link_speed = 2'd0;
  logic        full_duplex = 1'b0;
  logic        tx_strobe = 1'b0, rx_strobe = 1'b0, col_strobe = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = 16'h0000;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic [2:0]  led_out;

  int total = 0;
  int bad = 0;
  bit pol_hi = 1'b0;
  bit done = 1'b0;

  phy_led_ctrl #(.CLK_PER_MS(CPM), .PERIOD_MS(PMS), .STRETCH_MS(SMS), .N_LED(3)) dut (
    .clk(clk), .rst(rst), .link_up(link_up), .link_speed(link_speed),
    .full_duplex(full_duplex), .tx_strobe(tx_strobe), .rx_strobe(rx_strobe),
    .col_strobe(col_strobe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .led_out(led_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit lit(input int lane);
    return pol_hi ? led_out[lane] : !led_out[lane];
  endfunction

  // continuous waveform: lit count over P samples and circular toggles
  task automatic measure(input int lane, output int on, output int tog);
    bit prev, cur;
    on = 0; tog = 0;
    @(negedge clk);
    prev = lit(lane);
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      cur = lit(lane);
      if (cur) on++;
      if (cur != prev) tog++;
      prev = cur;
    end
  endtask

  // single strobe (0 tx, 1 rx, 2 col) then lit count over n cycles
  task automatic strobe_count(input int which, input int lane, input int n, output int on);
    @(negedge clk);
    tx_strobe = (which == 0); rx_strobe = (which == 1); col_strobe = (which == 2);
    @(negedge clk);
    tx_strobe = 1'b0; rx_strobe = 1'b0; col_strobe = 1'b0;
    on = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (lit(lane)) on++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int on, tog;
    idle(3);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk("R1 led_out", int'(led_out), 7);
    rd(16'h8078, v); chk("R1 rule0", int'(v), 0);
    rd(16'h8079, v); chk("R1 ctl0", int'(v), 0);
    rd(16'h901A, v); chk("R1 pol", int'(v), 0);

    // R2 register map
    for (int n = 0; n < 3; n++) begin
      wr(16'h8078 - 16'(2 * n), 16'h1110 * 16'(n + 1));
      wr(16'h8079 - 16'(2 * n), 16'h0005 + 16'(n));
    end
    wr(16'h8072, 16'hFFFF);
    wr(16'h8073, 16'hFFFF);
    wr(16'h1234, 16'hFFFF);
    for (int n = 0; n < 3; n++) begin
      rd(16'h8078 - 16'(2 * n), v); chk("R2 rule readback", int'(v), 'h1110 * (n + 1));
      rd(16'h8079 - 16'(2 * n), v); chk("R2 ctl readback", int'(v), 5 + n);
    end
    rd(16'h8072, v); chk("R2 index3 rule", int'(v), 0);
    rd(16'h8073, v); chk("R2 index3 ctl", int'(v), 0);
    rd(16'h1234, v); chk("R2 unmapped", int'(v), 0);
    for (int n = 0; n < 3; n++) wr(16'h8079 - 16'(2 * n), 16'h0000);

    // R5 exhaustive steady sweep, active low
    for (int j = 0; j < 64; j++) begin
      logic [15:0] pat;
      pat = 16'h0;
      pat[15] = j[0]; pat[12] = j[1]; pat[11] = j[2];
      pat[6] = j[3]; pat[5] = j[4]; pat[4] = j[5];
      for (int n = 0; n < 3; n++) wr(16'h8078 - 16'(2 * n), pat);
      for (int k = 0; k < 16; k++) begin
        bit e;
        @(negedge clk);
        link_up = k[0]; full_duplex = k[1]; link_speed = 2'(k >> 2);
        idle(2);
        e = link_up && ((pat[15] && link_speed == 3) || (pat[6] && link_speed == 2) ||
                        (pat[5] && link_speed == 1) || (pat[4] && link_speed == 0) ||
                        (pat[12] && full_duplex) || (pat[11] && !full_duplex));
        chk("R5 steady sweep", int'(led_out), e ? 0 : 7);
      end
    end

    // R9 polarity
    wr(16'h8078, 16'h0); wr(16'h8076, 16'h0); wr(16'h8074, 16'h0);
    wr(16'h8079, 16'hA000);  // LED0 lit
    wr(16'h8077, 16'h8000);  // LED1 dark
    idle(2);
    chk("R9 active low", int'(led_out[1:0]), 2);
    wr(16'h901A, 16'h0018); idle(2);
    chk("R9 other bits", int'(led_out[1:0]), 2);
    wr(16'h901A, 16'h0040); idle(2);
    pol_hi = 1'b1;
    chk("R9 active high", int'(led_out[1:0]), 1);

    // R3 forced codes override rules and link
    wr(16'h8078, 16'hFFFF); wr(16'h8076, 16'hFFFF);
    link_up = 1'b1; link_speed = 2'd2;
    wr(16'h8079, 16'h8000); wr(16'h8077, 16'hA000);
    idle(2);
    chk("R3 forced dark", int'(lit(0)), 0);
    chk("R3 forced lit", int'(lit(1)), 1);
    strobe_count(0, 0, P, on); chk("R3 dark ignores tx", on, 0);

    // R4 forced blinks
    wr(16'h8079, 16'hC000); measure(0, on, tog);
    chk("R4 slow on", on, P / 2); chk("R4 slow toggles", tog, 2);
    wr(16'h8079, 16'hE000); measure(0, on, tog);
    chk("R4 fast on", on, P / 2); chk("R4 fast toggles", tog, 4);

    // R10 speed blink with each waveform code
    wr(16'h8077, 16'h8000);
    link_speed = 2'd3;
    wr(16'h8078, 16'h4000);
    for (int c = 0; c < 4; c++) begin
      int eon, etog;
      wr(16'h8079, 16'(c << 13));
      measure(0, on, tog);
      eon = (c == 1) ? P / 4 : (c == 2) ? 3 * P / 4 : P / 2;
      etog = (c == 0) ? 4 : 2;
      chk("R10 R6 style on", on, eon); chk("R10 style toggles", tog, etog);
    end
    link_speed = 2'd1; idle(2);
    measure(0, on, tog); chk("R10 wrong speed", on, 0);

    // R6 activity blink hold, link down, bypass set
    link_up = 1'b0;
    wr(16'h8078, 16'h2400);
    for (int c = 0; c < 4; c++) begin
      int eon;
      wr(16'h8079, 16'(c << 13)); idle(2 * P);
      strobe_count(0, 0, 2 * P, on);
      eon = (c == 1) ? P / 4 : (c == 2) ? 3 * P / 4 : P / 2;
      chk("R6 tx hold duty", on, eon);
    end
    wr(16'h8078, 16'h2200); wr(16'h8079, 16'h6000); idle(2 * P);
    strobe_count(1, 0, 2 * P, on); chk("R6 rx hold", on, P / 2);
    strobe_count(0, 0, 2 * P, on); chk("R6 tx ignored by rx rule", on, 0);
    wr(16'h8078, 16'h2008); wr(16'h8079, 16'h4000); idle(2 * P);
    strobe_count(2, 0, 2 * P, on); chk("R6 col hold", on, 3 * P / 4);

    // R7 bypass gating
    link_up = 1'b1; link_speed = 2'd2;
    wr(16'h8079, 16'h0000);
    wr(16'h8078, 16'h0420); idle(2 * P);
    strobe_count(0, 0, 2 * P, on); chk("R7 no bypass mismatch", on, 0);
    wr(16'h8078, 16'h2420); idle(2 * P);
    strobe_count(0, 0, 2 * P, on); chk("R7 bypass", on, P / 2);
    wr(16'h8078, 16'h0440); idle(2 * P);
    strobe_count(0, 0, 2 * P, on); chk("R7 match steady plus blink", on, P / 2 + P);

    // R8 stretch
    link_up = 1'b0;
    wr(16'h8078, 16'h0100); idle(2 * P);
    strobe_count(0, 0, 3 * S, on); chk("R8 tx stretch", on, S);
    wr(16'h8078, 16'h0080); idle(2 * P);
    strobe_count(1, 0, 3 * S, on); chk("R8 rx stretch", on, S);
    strobe_count(0, 0, 3 * S, on); chk("R8 tx ignored by rx stretch", on, 0);

    // R3 R6 concurrent control write and tx strobe
    wr(16'h8078, 16'h2400); wr(16'h8079, 16'hA000); idle(2 * P);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 16'h8079; reg_wdata = 16'h0000; tx_strobe = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tx_strobe = 1'b0;
    on = 0;
    for (int i = 0; i < 2 * P; i++) begin
      @(negedge clk);
      if (lit(0)) on++;
    end
    chk("R6 strobe with ctl write", on, P / 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule